// File: doc/BRIEF.md
# Banked cartridge mapper with cycle-count interrupt

This block sits between a console's CPU and PPU buses and the cartridge ROMs. It turns a CPU address into a program ROM address through three writable 8 KB windows and one window pinned to the last bank. It turns a PPU pattern address into a character ROM address through eight writable 1 KB windows. It also holds a nametable mirroring select and a 16-bit interrupt timer that counts CPU cycles.

Software programs the block by writing to the upper half of the CPU space. Bits 14:12 of the address pick a register group. Inside the control group and the character group, bits 2:0 pick the register. The timer is armed in three steps: write both halves of a 16-bit start value, copy that value into the counter, then let it count down one step per CPU cycle. When the count reaches zero, the interrupt request goes high. The counter then stays at zero until software reloads it.

Top module: `cart_mapper`

## Requirements
- R1: Reset sets the three program windows and all eight character windows to bank 0, selects vertical mirroring (mirror_h_o = 0), disables the timer, clears the counter and the 16-bit start value, and drives irq_o low.
- R2: A write takes effect at the rising clock edge where cpu_we_i, cpu_ce_i and cpu_addr_i[15] are all high. When cpu_addr_i[14:12] is 000, 010 or 100, the write loads program window 0, 1 or 2 from the data byte. A CPU read at $8000+w*$2000 (w = 0..2) then gives prg_addr_o = {bank_w, cpu_addr_i[12:0]}.
- R3: CPU addresses $E000-$FFFF always map to the last program bank (all ones), and no write changes that.
- R4: A write with cpu_addr_i[14:12] = 011 loads character window cpu_addr_i[2:0] from the data byte. The output is chr_addr_o = {bank[ppu_addr_i[12:10]], ppu_addr_i[9:0]}.
- R5: A write with cpu_addr_i[14:12] = 001 and cpu_addr_i[2:0] = 1 sets mirror_h_o to data bit 7 (1 = horizontal, 0 = vertical).
- R6: Control register 5 writes the high byte of the 16-bit start value and control register 6 writes the low byte. Each write leaves the other byte as it was.
- R7: A write to control register 4 copies the start value into the counter and drops irq_o on the next edge.
- R8: While the timer is enabled and the counter is non-zero, the counter decrements at each edge where cpu_ce_i is high. irq_o rises at the edge where the count goes from 1 to 0, so N qualified cycles after a reload to N.
- R9: Once the counter is at zero it stays there and no further interrupt is raised. irq_o stays high until a write to control register 3 or 4.
- R10: A write to control register 3 sets the timer enable from data bit 7 and clears a pending irq_o. While disabled, the counter holds its value.
- R11: The following have no effect on any output: writes with cpu_addr_i[15] low or cpu_ce_i low, writes to control registers 0, 2 and 7, and writes with cpu_addr_i[14:12] of 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_ce_i | input | 1 | High for one clock per CPU cycle |
| ppu_addr_i | input | 13 | PPU pattern table address |
| prg_addr_o | output | 21 | Program ROM byte address |
| chr_addr_o | output | 18 | Character ROM byte address |
| mirror_h_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Each bank window gets a different data byte, so a swapped window index or a wrong group decode shows up as a wrong bank on the output. The character windows get eight distinct bytes with an offset pattern that has bits both set and clear. The timer runs from several start values: 5, 256 (only the high byte set) and 258 (only the low byte rewritten). These runs separate a byte-order mix-up, a missing latch hold and an off-by-one in when the interrupt fires. Further runs cover the count while disabled, gated by a cpu_ce_i that toggles, and held at zero for hundreds of cycles after it expires, which exposes wraparound and a second interrupt.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;
  localparam int PRG_WIN = 3;
  localparam int CHR_WIN = 8;
  localparam int PRG_OFS_W = 13;
  localparam int CHR_OFS_W = 10;
  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    GRP_PRG0 = 3'd0,
    GRP_CTRL = 3'd1,
    GRP_PRG1 = 3'd2,
    GRP_CHR  = 3'd3,
    GRP_PRG2 = 3'd4,
    GRP_NA5  = 3'd5,
    GRP_NA6  = 3'd6,
    GRP_NA7  = 3'd7
  } grp_e;

  localparam logic [2:0] SUB_MIRROR  = 3'd1;
  localparam logic [2:0] SUB_ENABLE  = 3'd3;
  localparam logic [2:0] SUB_RELOAD  = 3'd4;
  localparam logic [2:0] SUB_START_H = 3'd5;
  localparam logic [2:0] SUB_START_L = 3'd6;
endpackage

// File: rtl/mapper_bank_regs.sv
`timescale 1ns/1ps
module mapper_bank_regs
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_i,
  input  grp_e                                  grp_i,
  input  logic [2:0]                            sub_i,
  input  logic [7:0]                            data_i,
  output logic [PRG_WIN-1:0][PRG_BANK_W-1:0]    prg_bank_o,
  output logic [CHR_WIN-1:0][CHR_BANK_W-1:0]    chr_bank_o,
  output logic                                  mirror_h_o
);
  for (genvar g = 0; g < PRG_WIN; g++) begin : g_prg
    localparam grp_e MY_GRP = (g == 0) ? GRP_PRG0 : (g == 1) ? GRP_PRG1 : GRP_PRG2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prg_bank_o[g] <= '0;
      else if (wr_i && grp_i == MY_GRP) prg_bank_o[g] <= data_i[PRG_BANK_W-1:0];
    end
  end

  for (genvar g = 0; g < CHR_WIN; g++) begin : g_chr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chr_bank_o[g] <= '0;
      else if (wr_i && grp_i == GRP_CHR && sub_i == 3'(g))
        chr_bank_o[g] <= data_i[CHR_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mirror_h_o <= 1'b0;
    else if (wr_i && grp_i == GRP_CTRL && sub_i == SUB_MIRROR) mirror_h_o <= data_i[7];
  end
endmodule

// File: rtl/mapper_irq_timer.sv
`timescale 1ns/1ps
module mapper_irq_timer
  import mapper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             ctrl_wr_i,
  input  logic [2:0]       sub_i,
  input  logic [7:0]       data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] start_q;
  logic             reload, ack, tick;

  assign reload = ctrl_wr_i && sub_i == SUB_RELOAD;
  assign ack    = reload || (ctrl_wr_i && sub_i == SUB_ENABLE);
  assign tick   = en_o && ce_i && cnt_o != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      en_o    <= 1'b0;
    end else if (ctrl_wr_i) begin
      if (sub_i == SUB_START_H) start_q[15:8] <= data_i;
      if (sub_i == SUB_START_L) start_q[7:0]  <= data_i;
      if (sub_i == SUB_ENABLE)  en_o          <= data_i[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (reload) cnt_o <= start_q;
    else if (tick)   cnt_o <= cnt_o - 1'b1;
  end

  // acknowledge wins over a same-cycle expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       irq_o <= 1'b0;
    else if (ack)                      irq_o <= 1'b0;
    else if (tick && cnt_o == 16'd1)   irq_o <= 1'b1;
  end
endmodule

// File: rtl/mapper_addr_map.sv
`timescale 1ns/1ps
module mapper_addr_map
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 8,
  localparam int PRG_AW = PRG_BANK_W + PRG_OFS_W,
  localparam int CHR_AW = CHR_BANK_W + CHR_OFS_W
) (
  input  logic [1:0]                         cpu_win_i,
  input  logic [PRG_OFS_W-1:0]               cpu_ofs_i,
  input  logic [12:0]                        ppu_addr_i,
  input  logic [PRG_WIN-1:0][PRG_BANK_W-1:0] prg_bank_i,
  input  logic [CHR_WIN-1:0][CHR_BANK_W-1:0] chr_bank_i,
  output logic [PRG_AW-1:0]                  prg_addr_o,
  output logic [CHR_AW-1:0]                  chr_addr_o
);
  logic [PRG_BANK_W-1:0] prg_sel;

  always_comb begin
    case (cpu_win_i)
      2'd0:    prg_sel = prg_bank_i[0];
      2'd1:    prg_sel = prg_bank_i[1];
      2'd2:    prg_sel = prg_bank_i[2];
      default: prg_sel = '1;
    endcase
  end

  assign prg_addr_o = {prg_sel, cpu_ofs_i};
  assign chr_addr_o = {chr_bank_i[ppu_addr_i[12:10]], ppu_addr_i[CHR_OFS_W-1:0]};
endmodule

// File: rtl/cart_mapper.sv
`timescale 1ns/1ps
module cart_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int CHR_BANK_W = 8,
  localparam int PRG_AW = PRG_BANK_W + PRG_OFS_W,
  localparam int CHR_AW = CHR_BANK_W + CHR_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_we_i,
  input  logic              cpu_ce_i,
  input  logic [12:0]       ppu_addr_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic              mirror_h_o,
  output logic              irq_o
);
  logic                               wr_stb;
  grp_e                               grp;
  logic [PRG_WIN-1:0][PRG_BANK_W-1:0] prg_bank;
  logic [CHR_WIN-1:0][CHR_BANK_W-1:0] chr_bank;
  logic [CNT_W-1:0]                   tmr_cnt;
  logic                               tmr_en;

  assign wr_stb = cpu_we_i && cpu_ce_i && cpu_addr_i[15];
  assign grp    = grp_e'(cpu_addr_i[14:12]);

  mapper_bank_regs #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_stb), .grp_i(grp),
    .sub_i(cpu_addr_i[2:0]), .data_i(cpu_data_i),
    .prg_bank_o(prg_bank), .chr_bank_o(chr_bank), .mirror_h_o(mirror_h_o)
  );

  mapper_irq_timer u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(cpu_ce_i),
    .ctrl_wr_i(wr_stb && grp == GRP_CTRL), .sub_i(cpu_addr_i[2:0]),
    .data_i(cpu_data_i), .cnt_o(tmr_cnt), .en_o(tmr_en), .irq_o(irq_o)
  );

  mapper_addr_map #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_map (
    .cpu_win_i(cpu_addr_i[14:13]), .cpu_ofs_i(cpu_addr_i[PRG_OFS_W-1:0]),
    .ppu_addr_i(ppu_addr_i), .prg_bank_i(prg_bank), .chr_bank_i(chr_bank),
    .prg_addr_o(prg_addr_o), .chr_addr_o(chr_addr_o)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
`timescale 1ns/1ps
module cart_mapper_chk #(
  parameter int PRG_BANK_W = 8,
  localparam int PRG_AW = PRG_BANK_W + 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic              cpu_ce_i,
  input logic              wr_i,
  input logic [PRG_AW-1:0] prg_addr_o,
  input logic              irq_o,
  input logic              en_i,
  input logic [15:0]       cnt_i
);
  logic ctrl_wr, ack_wr, reload_wr;
  assign ctrl_wr   = wr_i && cpu_addr_i[14:12] == 3'b001;
  assign reload_wr = ctrl_wr && cpu_addr_i[2:0] == 3'd4;
  assign ack_wr    = reload_wr || (ctrl_wr && cpu_addr_i[2:0] == 3'd3);

  assert_fixed_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:13] == 3'b111 |-> prg_addr_o[PRG_AW-1 -: PRG_BANK_W] == '1);

  assert_reload_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_wr |=> !irq_o);

  assert_irq_from_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_i && cpu_ce_i && cnt_i == 16'd1));

  assert_stop_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == 16'd0 && !reload_wr) |=> cnt_i == 16'd0);

  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_wr) |=> irq_o);

  assert_enable_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr |=> !irq_o);

  assert_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (!$stable(cpu_addr_i) || $stable(prg_addr_o)));
endmodule

bind cart_mapper cart_mapper_chk #(.PRG_BANK_W(PRG_BANK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_ce_i(cpu_ce_i),
  .wr_i(wr_stb), .prg_addr_o(prg_addr_o), .irq_o(irq_o), .en_i(tmr_en),
  .cnt_i(tmr_cnt)
);

// File: tb/sim_cart_mapper.sv
`timescale 1ns/1ps
module sim_cart_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_we = 1'b0;
  logic        cpu_ce = 1'b1;
  logic [12:0] ppu_addr = 13'h0000;
  logic [20:0] prg_addr;
  logic [17:0] chr_addr;
  logic        mirror_h, irq;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  cart_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_we_i(cpu_we), .cpu_ce_i(cpu_ce), .ppu_addr_i(ppu_addr),
    .prg_addr_o(prg_addr), .chr_addr_o(chr_addr), .mirror_h_o(mirror_h), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic ce = 1'b1);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1; cpu_ce = ce;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0; cpu_ce = 1'b1; cpu_addr = 16'h0000;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic prg_is(input string req, input logic [15:0] a, input logic [7:0] bank);
    cpu_addr = a; #1;
    chk(req, 32'(prg_addr), 32'({bank, a[12:0]}));
    cpu_addr = 16'h0000;
  endtask

  task automatic t_reset;
    @(negedge clk);
    prg_is("R1", 16'h8abc, 8'h00);
    prg_is("R1", 16'hA001, 8'h00);
    prg_is("R1", 16'hDFFF, 8'h00);
    ppu_addr = 13'h1C05; #1;
    chk("R1", 32'(chr_addr), 32'h0005);
    chk("R1", 32'(mirror_h), 0);
    chk("R1", 32'(irq), 0);
  endtask

  task automatic t_prg;
    wr(16'h8000, 8'h11); wr(16'hA000, 8'h22); wr(16'hC000, 8'h33);
    prg_is("R2", 16'h8abc, 8'h11);
    prg_is("R2", 16'hA456, 8'h22);
    prg_is("R2", 16'hC001, 8'h33);
    prg_is("R3", 16'hE777, 8'hFF);
    wr(16'hE000, 8'h44);
    prg_is("R3", 16'hFFFF, 8'hFF);
    prg_is("R11", 16'h8000, 8'h11);
  endtask

  task automatic t_chr;
    for (int i = 0; i < 8; i++) wr(16'hB000 | 16'(i), 8'(8'h40 + 3 * i));
    for (int i = 0; i < 8; i++) begin
      ppu_addr = {3'(i), 10'h2A5}; #1;
      chk("R4", 32'(chr_addr), 32'({8'(8'h40 + 3 * i), 10'h2A5}));
    end
  endtask

  task automatic t_mirror;
    wr(16'h9001, 8'h80); chk("R5", 32'(mirror_h), 1);
    wr(16'h9001, 8'h7F); chk("R5", 32'(mirror_h), 0);
    wr(16'h9001, 8'hFF); chk("R5", 32'(mirror_h), 1);
  endtask

  task automatic t_ignore;
    wr(16'h0000, 8'h99);
    prg_is("R11", 16'h8000, 8'h11);
    wr(16'h8000, 8'h99, 1'b0);
    prg_is("R11", 16'h8000, 8'h11);
    wr(16'h9000, 8'h00); wr(16'h9002, 8'h00); wr(16'h9007, 8'h00);
    chk("R11", 32'(mirror_h), 1);
    wr(16'hD000, 8'h00); wr(16'hF003, 8'h00);
    prg_is("R11", 16'hA000, 8'h22);
    prg_is("R11", 16'hC000, 8'h33);
    ppu_addr = 13'h0C00; #1;
    chk("R11", 32'(chr_addr), 32'({8'h49, 10'h000}));
    chk("R11", 32'(irq), 0);
  endtask

  task automatic t_count;
    wr(16'h9003, 8'h80);
    wr(16'h9005, 8'h00); wr(16'h9006, 8'h05);
    edges(10); chk("R9", 32'(irq), 0);
    wr(16'h9004, 8'h00);
    edges(4); chk("R8", 32'(irq), 0);
    edges(1); chk("R8", 32'(irq), 1);
  endtask

  task automatic t_stop;
    edges(300); chk("R9", 32'(irq), 1);
    wr(16'h9003, 8'h80); chk("R10", 32'(irq), 0);
    edges(300); chk("R9", 32'(irq), 0);
  endtask

  task automatic t_start_bytes;
    wr(16'h9005, 8'h01); wr(16'h9006, 8'h00);
    wr(16'h9004, 8'h00);
    edges(255); chk("R6", 32'(irq), 0);
    edges(1);   chk("R6", 32'(irq), 1);
    wr(16'h9006, 8'h02);
    wr(16'h9004, 8'h00); chk("R7", 32'(irq), 0);
    edges(257); chk("R6", 32'(irq), 0);
    edges(1);   chk("R6", 32'(irq), 1);
  endtask

  task automatic t_disable;
    wr(16'h9003, 8'h00); chk("R10", 32'(irq), 0);
    wr(16'h9005, 8'h00); wr(16'h9006, 8'h03);
    wr(16'h9004, 8'h00);
    edges(20); chk("R10", 32'(irq), 0);
    wr(16'h9003, 8'h80);
    edges(2); chk("R10", 32'(irq), 0);
    edges(1); chk("R10", 32'(irq), 1);
  endtask

  task automatic t_ce_gate;
    wr(16'h9006, 8'h04);
    wr(16'h9004, 8'h00);
    for (int i = 1; i <= 8; i++) begin
      cpu_ce = (i % 2 == 0);
      @(posedge clk); @(negedge clk);
      if (i == 7) chk("R8", 32'(irq), 0);
    end
    cpu_ce = 1'b1;
    chk("R8", 32'(irq), 1);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_prg();
    t_chr();
    t_mirror();
    t_ignore();
    t_count();
    t_stop();
    t_start_bytes();
    t_disable();
    t_ce_gate();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule